// File: doc/BRIEF.md
# Hierarchical Interrupt Aggregation Controller

This block gathers single-cycle event pulses from the peripherals of a baseband processor. It turns them into three active-low request lines for a host microcontroller. The first line is a frame tick. It is held low from the start of a frame until the host touches the mode register. The second line is a combined request that is reduced in two levels. Sticky condition flags are grouped into three peripheral groups: hardware control, serial link and serial bus. Each group yields a live group flag, and a top-level enable gates each group flag onto the line. The third line is a maskable high-priority request. It is fed by the radio-bus trigger pulses, the frame tick and the DSP host port.

The host uses a plain synchronous register bus. A select strobe with a write qualifier, a 4-bit address and 16-bit write data form one access per cycle. Read data is presented combinationally during the access cycle. Event inputs and the register bus are control pins with no handshake. Every pulse is taken in the cycle it is high, and no back-pressure exists.

Address map (word addresses): 0 mode, 1 hardware-control flags, 2 serial-link flags, 3 serial-link enables, 4 serial-bus flags, 5 serial-bus enables, 6 combined register, 7 high-priority flags, 8 high-priority mask.

Top module: `irq_hub`

## Requirements
- R1: While `rst_n` is low at a clock edge, every flag, enable and the mode register clear to 0, and all three request lines read 1 after that edge.
- R2: A `frame_start_i` pulse drives `frame_irq_n_o` low from the following cycle. The line stays low through idle cycles and through accesses to addresses other than 0.
- R3: Any access to address 0, read or write, releases `frame_irq_n_o` high after that edge. A `frame_start_i` pulse in the same cycle as the access keeps the line low. Address 0 stores and returns a 16-bit mode value.
- R4: Condition flags at addresses 1, 2, 4 and 7 are sticky. Bit i is set by its event pulse and cleared by a write with data bit i at 1. A 0 in the written data leaves the bit unchanged. A set and a clear of the same bit in one cycle leave it set.
- R5: A group flag is the OR over its conditions of (flag AND enable). The enables are the per-bit enables at address 3 for the serial-link group and address 5 for the serial-bus group. The hardware-control group has no enable register, so its group flag is the OR of its flags. The group flags read at address 6 bits [2:0] in the order hardware, link, bus.
- R6: Address 6 bits [5:3] are the read/write top-level enables, in the same group order. `comb_irq_n_o` is low exactly when some group flag has its top-level enable set.
- R7: The high-priority flag bits are ordered radio triggers at bits [RF_W-1:0], the frame tick at bit RF_W, and the host port at bit RF_W+1. Each flag bit is matched by the same bit of the mask at address 8. `hipr_irq_n_o` is low exactly when some flag bit has its mask bit set.
- R8: Register bits above a field's width read 0. Addresses 9 to 15 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start_i | input | 1 | Frame-start pulse |
| hw_ev_i | input | HW_W | Hardware-control event pulses |
| link_ev_i | input | LINK_W | Serial-link event pulses |
| sbus_ev_i | input | SBUS_W | Serial-bus event pulses |
| rf_trig_i | input | RF_W | Radio-bus trigger pulses |
| host_port_ev_i | input | 1 | DSP host-port event pulse |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Access is a write |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the current access |
| frame_irq_n_o | output | 1 | Frame request, active low |
| comb_irq_n_o | output | 1 | Combined request, active low |
| hipr_irq_n_o | output | 1 | High-priority request, active low |

## Verification
All 16 serial-link enable values are swept against a fixed flag pattern. Enables that hit a raised flag must show the group flag, and enables that hit only clear flags must not. This separates a true AND-OR reduction from a plain OR of the flags or of the enables. A full 8×8 sweep of group states against top-level enables checks both the combined readback and the request line. A 64-value mask sweep over a fixed high-priority flag pattern does the same for the third line. Same-cycle collisions (set against clear, frame pulse against mode access) are driven on purpose to tell the set-wins ordering from the opposite one.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_MODE     = 4'd0,
    RA_HW_FLAG  = 4'd1,
    RA_LINK_FLG = 4'd2,
    RA_LINK_EN  = 4'd3,
    RA_SBUS_FLG = 4'd4,
    RA_SBUS_EN  = 4'd5,
    RA_COMB     = 4'd6,
    RA_HP_FLAG  = 4'd7,
    RA_HP_MASK  = 4'd8
  } reg_addr_e;

  localparam int NUM_GROUPS = 3;
  localparam int GRP_HW   = 0;
  localparam int GRP_LINK = 1;
  localparam int GRP_SBUS = 2;
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)        q[i] <= 1'b0;
      else if (set_i[i]) q[i] <= 1'b1;
      else if (clr_i[i]) q[i] <= 1'b0;
    end
  end

  assign flags_o = q;

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i)));

  // R4
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((flags_o & $past(clr_i & ~set_i)) == '0));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i == '0) && (clr_i == '0)) |=> $stable(flags_o));
endmodule

// File: rtl/irq_group_reduce.sv
module irq_group_reduce #(
  parameter int W      = 4,
  parameter bit HAS_EN = 1'b1
) (
  input  logic [W-1:0] cond_i,
  input  logic [W-1:0] en_i,
  output logic         any_o
);
  logic [W-1:0] gated;

  if (HAS_EN) begin : g_masked
    assign gated = cond_i & en_i;
  end else begin : g_open
    logic [W-1:0] unused_en;
    assign unused_en = en_i;
    assign gated = cond_i;
  end

  assign any_o = |gated;

  // R5
  always_comb begin
    if (HAS_EN && en_i == '0)
      no_enable_chk: assert (!any_o);
  end
endmodule

// File: rtl/irq_frame_latch.sv
module irq_frame_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic access_i,
  output logic active_o
);
  logic q;

  always_ff @(posedge clk) begin
    if (!rst_n)        q <= 1'b0;
    else if (start_i)  q <= 1'b1;
    else if (access_i) q <= 1'b0;
  end

  assign active_o = q;

  // R2
  frame_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> active_o);

  // R3
  frame_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access_i && !start_i) |=> !active_o);

  // R2
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!access_i && !start_i) |=> $stable(active_o));
endmodule

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q_o <= '0;
    else if (we_i) q_o <= d_i;
  end

  // R6
  en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (q_o == $past(d_i)));
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int HW_W   = 4,
  parameter int LINK_W = 4,
  parameter int SBUS_W = 4,
  parameter int RF_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start_i,
  input  logic [HW_W-1:0]   hw_ev_i,
  input  logic [LINK_W-1:0] link_ev_i,
  input  logic [SBUS_W-1:0] sbus_ev_i,
  input  logic [RF_W-1:0]   rf_trig_i,
  input  logic              host_port_ev_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [3:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              frame_irq_n_o,
  output logic              comb_irq_n_o,
  output logic              hipr_irq_n_o
);
  localparam int HP_W      = RF_W + 2;
  localparam int HP_FRAME  = RF_W;
  localparam int HP_HOST   = RF_W + 1;
  localparam int COMB_EN_L = NUM_GROUPS;
  localparam int COMB_EN_H = 2 * NUM_GROUPS - 1;

  // Decode
  logic wr, mode_acc;
  assign wr       = bus_sel_i && bus_we_i;
  assign mode_acc = bus_sel_i && (bus_addr_i == RA_MODE);

  function automatic logic wr_to(input logic [3:0] a, input reg_addr_e r);
    return wr && (a == r);
  endfunction

  // Mode register
  logic [DATA_W-1:0] mode_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                        mode_q <= '0;
    else if (wr_to(bus_addr_i, RA_MODE)) mode_q <= bus_wdata_i;
  end

  // Frame latch
  logic frame_act;
  irq_frame_latch u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (frame_start_i),
    .access_i (mode_acc),
    .active_o (frame_act)
  );

  // Sticky condition flags
  logic [HW_W-1:0]   hw_flg,   hw_clr;
  logic [LINK_W-1:0] link_flg, link_clr;
  logic [SBUS_W-1:0] sbus_flg, sbus_clr;
  logic [HP_W-1:0]   hp_flg,   hp_clr, hp_set;

  assign hw_clr   = wr_to(bus_addr_i, RA_HW_FLAG)  ? bus_wdata_i[HW_W-1:0]   : '0;
  assign link_clr = wr_to(bus_addr_i, RA_LINK_FLG) ? bus_wdata_i[LINK_W-1:0] : '0;
  assign sbus_clr = wr_to(bus_addr_i, RA_SBUS_FLG) ? bus_wdata_i[SBUS_W-1:0] : '0;
  assign hp_clr   = wr_to(bus_addr_i, RA_HP_FLAG)  ? bus_wdata_i[HP_W-1:0]   : '0;
  assign hp_set   = {host_port_ev_i, frame_start_i, rf_trig_i};

  irq_sticky_bank #(.W(HW_W)) u_hw_flags (
    .clk(clk), .rst_n(rst_n), .set_i(hw_ev_i), .clr_i(hw_clr), .flags_o(hw_flg));
  irq_sticky_bank #(.W(LINK_W)) u_link_flags (
    .clk(clk), .rst_n(rst_n), .set_i(link_ev_i), .clr_i(link_clr), .flags_o(link_flg));
  irq_sticky_bank #(.W(SBUS_W)) u_sbus_flags (
    .clk(clk), .rst_n(rst_n), .set_i(sbus_ev_i), .clr_i(sbus_clr), .flags_o(sbus_flg));
  irq_sticky_bank #(.W(HP_W)) u_hp_flags (
    .clk(clk), .rst_n(rst_n), .set_i(hp_set), .clr_i(hp_clr), .flags_o(hp_flg));

  // Enable registers
  logic [LINK_W-1:0]     link_en;
  logic [SBUS_W-1:0]     sbus_en;
  logic [HP_W-1:0]       hp_mask;
  logic [NUM_GROUPS-1:0] comb_en;

  irq_en_reg #(.W(LINK_W)) u_link_en (
    .clk(clk), .rst_n(rst_n), .we_i(wr_to(bus_addr_i, RA_LINK_EN)),
    .d_i(bus_wdata_i[LINK_W-1:0]), .q_o(link_en));
  irq_en_reg #(.W(SBUS_W)) u_sbus_en (
    .clk(clk), .rst_n(rst_n), .we_i(wr_to(bus_addr_i, RA_SBUS_EN)),
    .d_i(bus_wdata_i[SBUS_W-1:0]), .q_o(sbus_en));
  irq_en_reg #(.W(HP_W)) u_hp_mask (
    .clk(clk), .rst_n(rst_n), .we_i(wr_to(bus_addr_i, RA_HP_MASK)),
    .d_i(bus_wdata_i[HP_W-1:0]), .q_o(hp_mask));
  irq_en_reg #(.W(NUM_GROUPS)) u_comb_en (
    .clk(clk), .rst_n(rst_n), .we_i(wr_to(bus_addr_i, RA_COMB)),
    .d_i(bus_wdata_i[COMB_EN_H:COMB_EN_L]), .q_o(comb_en));

  // Level 1: group reduction
  logic [NUM_GROUPS-1:0] grp;

  irq_group_reduce #(.W(HW_W), .HAS_EN(1'b0)) u_grp_hw (
    .cond_i(hw_flg), .en_i({HW_W{1'b1}}), .any_o(grp[GRP_HW]));
  irq_group_reduce #(.W(LINK_W), .HAS_EN(1'b1)) u_grp_link (
    .cond_i(link_flg), .en_i(link_en), .any_o(grp[GRP_LINK]));
  irq_group_reduce #(.W(SBUS_W), .HAS_EN(1'b1)) u_grp_sbus (
    .cond_i(sbus_flg), .en_i(sbus_en), .any_o(grp[GRP_SBUS]));

  // Level 2 and high-priority reduction
  logic comb_any, hp_any;

  irq_group_reduce #(.W(NUM_GROUPS), .HAS_EN(1'b1)) u_comb_top (
    .cond_i(grp), .en_i(comb_en), .any_o(comb_any));
  irq_group_reduce #(.W(HP_W), .HAS_EN(1'b1)) u_hp_top (
    .cond_i(hp_flg), .en_i(hp_mask), .any_o(hp_any));

  // Output drivers
  assign frame_irq_n_o = ~frame_act;
  assign comb_irq_n_o  = ~comb_any;
  assign hipr_irq_n_o  = ~hp_any;

  // Read mux
  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_we_i) begin
      case (bus_addr_i)
        RA_MODE:     bus_rdata_o = mode_q;
        RA_HW_FLAG:  bus_rdata_o[HW_W-1:0]   = hw_flg;
        RA_LINK_FLG: bus_rdata_o[LINK_W-1:0] = link_flg;
        RA_LINK_EN:  bus_rdata_o[LINK_W-1:0] = link_en;
        RA_SBUS_FLG: bus_rdata_o[SBUS_W-1:0] = sbus_flg;
        RA_SBUS_EN:  bus_rdata_o[SBUS_W-1:0] = sbus_en;
        RA_COMB: begin
          bus_rdata_o[NUM_GROUPS-1:0]      = grp;
          bus_rdata_o[COMB_EN_H:COMB_EN_L] = comb_en;
        end
        RA_HP_FLAG:  bus_rdata_o[HP_W-1:0] = hp_flg;
        RA_HP_MASK:  bus_rdata_o[HP_W-1:0] = hp_mask;
        default:     bus_rdata_o = '0;
      endcase
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (frame_irq_n_o && comb_irq_n_o && hipr_irq_n_o));

  // R6
  comb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (comb_en == '0) |-> comb_irq_n_o);

  // R7
  hp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_mask == '0) |-> hipr_irq_n_o);

  // R7
  hp_frame_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |=> (hp_flg[HP_FRAME] && !frame_irq_n_o));

  // R7
  hp_host_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_port_ev_i |=> hp_flg[HP_HOST]);
endmodule

// File: tb/irq_hub_bench.sv
`timescale 1ns/100ps
module irq_hub_bench;
  localparam int DATA_W = 16;
  localparam int RF_W   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic [3:0] hw_ev = '0, link_ev = '0, sbus_ev = '0, rf_trig = '0;
  logic host_ev = 1'b0;
  logic sel = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0, rdata;
  logic frame_n, comb_n, hipr_n;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_hub u_irq_hub (
    .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start),
    .hw_ev_i(hw_ev), .link_ev_i(link_ev), .sbus_ev_i(sbus_ev),
    .rf_trig_i(rf_trig), .host_port_ev_i(host_ev),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .frame_irq_n_o(frame_n), .comb_irq_n_o(comb_n), .hipr_irq_n_o(hipr_n));

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; we = 0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); sel = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [15:0] exp, input string tag);
    logic [15:0] d;
    rd(a, d);
    check({16'h0, d}, {16'h0, exp}, tag);
  endtask

  task automatic pulse(input logic fr, input logic [3:0] hw, input logic [3:0] lk,
                       input logic [3:0] sb, input logic [3:0] rf, input logic hp);
    @(negedge clk);
    frame_start = fr; hw_ev = hw; link_ev = lk; sbus_ev = sb; rf_trig = rf; host_ev = hp;
    @(negedge clk);
    frame_start = 0; hw_ev = '0; link_ev = '0; sbus_ev = '0; rf_trig = '0; host_ev = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check({frame_n, comb_n, hipr_n}, 3'b111, "R1 outputs idle");
    for (int a = 0; a < 9; a++) rd_chk(a[3:0], 16'h0, "R1 register zero");

    // R2 frame pulse
    pulse(1, 0, 0, 0, 0, 0);
    check(frame_n, 0, "R2 frame low after pulse");
    repeat (4) @(negedge clk);
    check(frame_n, 0, "R2 frame held idle");
    rd(4'd1, d);
    wr(4'd9, 16'h1);
    check(frame_n, 0, "R2 frame held other access");

    // R3 release by read, by write, collision
    rd(4'd0, d);
    check(frame_n, 1, "R3 released by read");
    pulse(1, 0, 0, 0, 0, 0);
    wr(4'd0, 16'hA55A);
    check(frame_n, 1, "R3 released by write");
    rd_chk(4'd0, 16'hA55A, "R3 mode readback");
    @(negedge clk); sel = 1; we = 0; addr = 4'd0; frame_start = 1;
    @(negedge clk); sel = 0; frame_start = 0;
    check(frame_n, 0, "R3 pulse beats access");

    // R4 sticky flags
    pulse(0, 4'b0101, 0, 0, 0, 0);
    rd_chk(4'd1, 16'h5, "R4 set by event");
    wr(4'd1, 16'h0);
    rd_chk(4'd1, 16'h5, "R4 zero write keeps");
    wr(4'd1, 16'h1);
    rd_chk(4'd1, 16'h4, "R4 w1c clears");
    @(negedge clk); hw_ev = 4'b0100; sel = 1; we = 1; addr = 4'd1; wdata = 16'h4;
    @(negedge clk); hw_ev = '0; sel = 0; we = 0; wdata = '0;
    rd_chk(4'd1, 16'h4, "R4 set wins over clear");
    wr(4'd1, 16'hF);

    // R5 link enable sweep, flags 1010
    pulse(0, 0, 4'b1010, 4'b0001, 0, 0);
    rd_chk(4'd2, 16'hA, "R4 link flags");
    for (int e = 0; e < 16; e++) begin
      wr(4'd3, 16'(e));
      rd(4'd6, d);
      check(d[1], ((e & 'hA) != 0), "R5 link group flag");
    end
    check(comb_n, 1, "R6 no top enable");

    // R5/R6 full group x top-enable sweep
    for (int g = 0; g < 8; g++) begin
      wr(4'd1, 16'hF);
      if (g[0]) pulse(0, 4'b0001, 0, 0, 0, 0);
      wr(4'd3, g[1] ? 16'hA : 16'h0);
      wr(4'd5, g[2] ? 16'h1 : 16'h0);
      for (int c = 0; c < 8; c++) begin
        wr(4'd6, 16'(c << 3));
        rd(4'd6, d);
        check(d, 16'((c << 3) | g), "R5 comb readback");
        check(comb_n, ((g & c) == 0), "R6 comb line");
      end
    end

    // R7 bit mapping and mask sweep
    wr(4'd7, 16'h3F);
    pulse(1, 0, 0, 0, 0, 0);
    rd_chk(4'd7, 16'h10, "R7 frame bit");
    wr(4'd7, 16'h3F);
    pulse(0, 0, 0, 0, 4'b1010, 1);
    rd_chk(4'd7, 16'h2A, "R7 rf and host bits");
    for (int m = 0; m < 64; m++) begin
      wr(4'd8, 16'(m));
      check(hipr_n, ((m & 'h2A) == 0), "R7 hipr line");
    end

    // R8 unused bits and unknown addresses
    wr(4'd3, 16'hFFFF);
    rd_chk(4'd3, 16'h000F, "R8 upper bits zero");
    wr(4'd6, 16'hFFFF);
    rd(4'd6, d);
    check(d[15:6], 0, "R8 comb upper zero");
    wr(4'd12, 16'hFFFF);
    rd_chk(4'd12, 16'h0, "R8 unknown reads zero");
    rd_chk(4'd8, 16'h3F, "R8 unknown write no effect");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule